// File: doc/BRIEF.md
# Framed Serial Transmit Shifter

This block turns parallel transmit words into a serial bit stream on one data line. It is clocked by the bit clock itself: every rising edge of `clk` is one bit time. A frame begins at the first edge on which `fsync` is sampled high while the shifter is idle. At that edge the word waiting in a one-entry holding register is taken, and its bits leave on `txd` after a programmable delay of zero, one or two bit clocks.

Words enter through a valid/ready load port. `in_ready` is high exactly while the holding register is empty; a word is accepted on an edge where `in_valid` and `in_ready` are both high. The producer must keep `in_valid` and `in_data` steady until that edge. No back-pressure exists on the serial side: the frame sync decides when a word is consumed, and a frame that starts with an empty holding register sends an all-zero word.

The configuration inputs (data delay, word length, bit order) are sampled only at frame start. A 16-bit word is sent from bit 15 downward, so an A-law code placed left-justified in bits 15..3 with zeros in bits 2..0 leaves first, followed by the three pad bits.

Top module: `framed_tx_shifter`

## Requirements
- R1: After reset, `txd`, `dly_err` and `overrun` are 0, and `in_ready` and `hold_empty` are 1.
- R2: `dly_code` selects the data delay: 00 = 0, 01 = 1, 10 = 2 bit clocks. With delay 0 the first data bit appears on `txd` in the bit-clock cycle that follows the frame-start edge. Each delay step moves it one cycle later.
- R3: `dly_code` 11 is treated as a delay of 0. `dly_err` goes to 1 at that frame start and holds until the next accepted frame start, which recomputes it.
- R4: `len_code` sets the word length: 00 = 8, 01 = 12, 10 or 11 = 16 bits. With `ord_code` other than 01, bits L-1 down to 0 of the word are sent most significant first.
- R5: A 16-bit word is sent bit 15 first and bit 0 last, so a left-justified A-law code (bits 15..3, with bits 2..0 zero) ends with three 0 bits.
- R6: With `ord_code` = 01, bits 0 through 7 of the word are sent in that order (LSB first), always as an 8-bit word, whatever `len_code` says.
- R7: `txd` is 0 when no frame is in progress, during the delay bits, and after the last bit until the next frame's data.
- R8: A high `fsync` seen while a frame (delay or data) is in progress is ignored: the word in flight is unchanged, and `overrun` becomes 1 until the next accepted frame start. An `fsync` on the edge right after the last data bit is accepted, which gives back-to-back frames.
- R9: A word accepted on the load port makes `hold_empty` 0. Frame start consumes it and sets `hold_empty` to 1. A frame that starts while the holding register is empty sends zeros.
- R10: Changing `dly_code`, `len_code` or `ord_code` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame synchronization, sampled each edge |
| dly_code | input | 2 | Data delay select (00/01/10, 11 reserved) |
| len_code | input | 2 | Word length select (8/12/16/16) |
| ord_code | input | 2 | Bit order select (01 = LSB first, 8-bit) |
| in_valid | input | 1 | Load port: word offered |
| in_ready | output | 1 | Load port: holding register can take a word |
| in_data | input | 16 | Load port: transmit word |
| hold_empty | output | 1 | Holding register has no word |
| txd | output | 1 | Serial data out |
| dly_err | output | 1 | Current frame used the reserved delay code |
| overrun | output | 1 | A frame sync arrived during a frame |

## Verification
The hardest case to reach is the boundary between two frames. The edge right after the last data bit must accept a new frame sync, while the edge before it must reject one. The bench records the cycle of the first frame sync, loads the second word while the first is still shifting, and raises the next sync on exactly the cycle after the last bit. In a separate frame it pulses the sync mid-word to prove that case is ignored. A further frame changes every configuration input one cycle after frame start, to show the word in flight keeps its settings.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int NARROW_W = 8;
  localparam int LEN_STEP = 4;
  localparam logic [1:0] DLY_RSVD = 2'b11;
  localparam logic [1:0] ORD_LSB  = 2'b01;
endpackage

// File: rtl/ftx_hold_reg.sv
module ftx_hold_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              take,
  output logic [WORD_W-1:0] word,
  output logic              empty
);
  logic              full_q;
  logic [WORD_W-1:0] data_q;

  assign in_ready = ~full_q;
  assign empty    = ~full_q;
  assign word     = full_q ? data_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) full_q <= 1'b0;
      if (in_valid && in_ready) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end
    end
  end

  // R9
  load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !empty);
  // R9
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(in_valid && in_ready)) |=> empty);
endmodule

// File: rtl/ftx_cfg_decode.sv
module ftx_cfg_decode
  import ftx_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic [1:0]        dly_code,
  input  logic [1:0]        len_code,
  input  logic [1:0]        ord_code,
  input  logic [WORD_W-1:0] word,
  output logic [1:0]        eff_dly,
  output logic [CNT_W-1:0]  eff_len,
  output logic [WORD_W-1:0] aligned,
  output logic              dly_err
);
  logic [NARROW_W-1:0] rev_byte;

  for (genvar i = 0; i < NARROW_W; i++) begin : g_rev
    assign rev_byte[i] = word[NARROW_W-1-i];
  end

  always_comb begin
    int len_i;
    dly_err = (dly_code == DLY_RSVD);
    eff_dly = dly_err ? 2'b00 : dly_code;
    len_i   = NARROW_W + LEN_STEP * int'(len_code);
    if (len_i > WORD_W) len_i = WORD_W;
    if (ord_code == ORD_LSB) begin
      eff_len = CNT_W'(NARROW_W);
      aligned = {rev_byte, {(WORD_W-NARROW_W){1'b0}}};
    end else begin
      eff_len = CNT_W'(len_i);
      aligned = word << (WORD_W - len_i);
    end
  end

  // R2
  always_comb eff_dly_range_chk: assert (eff_dly != DLY_RSVD);
endmodule

// File: rtl/ftx_shift_core.sv
module ftx_shift_core #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [WORD_W-1:0] aligned,
  input  logic [1:0]        eff_dly,
  input  logic [CNT_W-1:0]  eff_len,
  input  logic              dly_err_in,
  output logic              take,
  output logic              txd,
  output logic              dly_err,
  output logic              overrun
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  bits_q;
  logic [1:0]        wait_q;
  logic              busy;

  assign busy = (bits_q != '0) || (wait_q != '0);
  assign take = fsync && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bits_q  <= '0;
      wait_q  <= '0;
      txd     <= 1'b0;
      dly_err <= 1'b0;
      overrun <= 1'b0;
    end else if (take) begin
      dly_err <= dly_err_in;
      overrun <= 1'b0;
      if (eff_dly == 2'b00) begin
        txd    <= aligned[WORD_W-1];
        sh_q   <= {aligned[WORD_W-2:0], 1'b0};
        bits_q <= eff_len - CNT_W'(1);
        wait_q <= '0;
      end else begin
        txd    <= 1'b0;
        sh_q   <= aligned;
        bits_q <= eff_len;
        wait_q <= eff_dly - 2'd1;
      end
    end else begin
      if (fsync) overrun <= 1'b1;
      if (wait_q != '0) begin
        wait_q <= wait_q - 2'd1;
        txd    <= 1'b0;
      end else if (bits_q != '0) begin
        txd    <= sh_q[WORD_W-1];
        sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
        bits_q <= bits_q - CNT_W'(1);
      end else begin
        txd <= 1'b0;
      end
    end
  end

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txd |-> $past(take || busy));
  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && busy) |=> overrun);
  // R8
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && wait_q == '0 && bits_q != '0) |=> (bits_q == $past(bits_q) - CNT_W'(1)));
  // R3
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dly_err_in) |=> dly_err);
endmodule

// File: rtl/framed_tx_shifter.sv
module framed_tx_shifter
  import ftx_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [1:0]        dly_code,
  input  logic [1:0]        len_code,
  input  logic [1:0]        ord_code,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              hold_empty,
  output logic              txd,
  output logic              dly_err,
  output logic              overrun
);
  logic              take;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] aligned;
  logic [1:0]        eff_dly;
  logic [CNT_W-1:0]  eff_len;
  logic              dly_err_c;

  ftx_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .take(take), .word(word), .empty(hold_empty)
  );

  ftx_cfg_decode #(.WORD_W(WORD_W)) u_dec (
    .dly_code(dly_code), .len_code(len_code), .ord_code(ord_code),
    .word(word), .eff_dly(eff_dly), .eff_len(eff_len),
    .aligned(aligned), .dly_err(dly_err_c)
  );

  ftx_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .aligned(aligned),
    .eff_dly(eff_dly), .eff_len(eff_len), .dly_err_in(dly_err_c),
    .take(take), .txd(txd), .dly_err(dly_err), .overrun(overrun)
  );
endmodule

// File: tb/framed_tx_shifter_bench.sv
module framed_tx_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [1:0]  dly_code = 2'b00;
  logic [1:0]  len_code = 2'b00;
  logic [1:0]  ord_code = 2'b00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        hold_empty;
  logic        txd;
  logic        dly_err;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int at; bit val; string req; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  framed_tx_shifter u_framed_tx_shifter (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .dly_code(dly_code),
    .len_code(len_code), .ord_code(ord_code), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .hold_empty(hold_empty),
    .txd(txd), .dly_err(dly_err), .overrun(overrun)
  );

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: compares txd with the scoreboard at each falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.at < cyc) check(1'b0, e.req, -1, int'(e.val));
      else check(txd == e.val, e.req, int'(txd), int'(e.val));
    end
  end

  task automatic load_word(logic [15:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Called at a falling edge; frame starts on the next rising edge.
  task automatic start_frame(logic [15:0] w, logic [1:0] d, logic [1:0] lc,
                             logic [1:0] oc, bit trail, string req);
    int base;
    int dd;
    int len;
    dly_code = d; len_code = lc; ord_code = oc;
    fsync = 1'b1;
    base = cyc + 1;
    dd = (d == 2'b11) ? 0 : int'(d);
    for (int i = 0; i < dd; i++) q.push_back('{base + i, 1'b0, "R7"});
    if (oc == 2'b01) begin
      len = 8;
      for (int i = 0; i < 8; i++) q.push_back('{base + dd + i, w[i], req});
    end else begin
      len = 8 + 4 * int'(lc);
      if (len > 16) len = 16;
      for (int i = 0; i < len; i++) q.push_back('{base + dd + i, w[len-1-i], req});
    end
    if (trail) q.push_back('{base + dd + len, 1'b0, "R7"});
    @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b0, "R1", int'(txd), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    check(hold_empty == 1'b1, "R1", int'(hold_empty), 1);
    check(dly_err == 1'b0 && overrun == 1'b0, "R1", int'({dly_err, overrun}), 0);

    // R2 delays 0, 1, 2 with 8-bit MSB-first words
    load_word(16'h00A5);
    check(hold_empty == 1'b0, "R9", int'(hold_empty), 0);
    start_frame(16'h00A5, 2'b00, 2'b00, 2'b00, 1'b1, "R2");
    check(hold_empty == 1'b1, "R9", int'(hold_empty), 1);
    drain();
    load_word(16'h0093);
    start_frame(16'h0093, 2'b01, 2'b00, 2'b00, 1'b1, "R2");
    drain();
    load_word(16'h00C6);
    start_frame(16'h00C6, 2'b10, 2'b00, 2'b00, 1'b1, "R2");
    drain();

    // R3 reserved delay code
    load_word(16'h0071);
    start_frame(16'h0071, 2'b11, 2'b00, 2'b00, 1'b1, "R3");
    check(dly_err == 1'b1, "R3", int'(dly_err), 1);
    drain();
    check(dly_err == 1'b1, "R3", int'(dly_err), 1);

    // R4 12-bit word; dly_err recomputed at this start
    load_word(16'hFABC);
    start_frame(16'hFABC, 2'b00, 2'b01, 2'b00, 1'b1, "R4");
    check(dly_err == 1'b0, "R3", int'(dly_err), 0);
    drain();
    load_word(16'h3C5A);
    start_frame(16'h3C5A, 2'b01, 2'b11, 2'b10, 1'b1, "R4");
    drain();

    // R5 left-justified A-law word
    load_word(16'hB5A8);
    start_frame(16'hB5A8, 2'b01, 2'b10, 2'b00, 1'b1, "R5");
    drain();

    // R6 LSB first, with 8-bit and 16-bit length codes
    load_word(16'h00C5);
    start_frame(16'h00C5, 2'b00, 2'b00, 2'b01, 1'b1, "R6");
    drain();
    load_word(16'hFF3A);
    start_frame(16'hFF3A, 2'b01, 2'b10, 2'b01, 1'b1, "R6");
    drain();

    // R8 sync during a frame is ignored and flagged
    load_word(16'h96E1);
    start_frame(16'h96E1, 2'b00, 2'b10, 2'b00, 1'b1, "R8");
    repeat (4) @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    check(overrun == 1'b1, "R8", int'(overrun), 1);
    drain();
    check(overrun == 1'b1, "R8", int'(overrun), 1);
    load_word(16'h005C);
    start_frame(16'h005C, 2'b00, 2'b00, 2'b00, 1'b1, "R8");
    check(overrun == 1'b0, "R8", int'(overrun), 0);
    drain();

    // R8 back-to-back frames: next sync on the edge after the last bit
    load_word(16'h00B4);
    s = cyc;
    start_frame(16'h00B4, 2'b00, 2'b00, 2'b00, 1'b0, "R8");
    load_word(16'h002D);
    while (cyc < s + 8) @(negedge clk);
    start_frame(16'h002D, 2'b00, 2'b00, 2'b00, 1'b1, "R8");
    check(overrun == 1'b0, "R8", int'(overrun), 0);
    drain();

    // R10 configuration changes mid-frame have no effect
    load_word(16'hE1D3);
    start_frame(16'hE1D3, 2'b00, 2'b10, 2'b00, 1'b1, "R10");
    dly_code = 2'b10; len_code = 2'b00; ord_code = 2'b01;
    drain();

    // R9 frame with empty holding register sends zeros
    check(in_ready == 1'b1 && hold_empty == 1'b1, "R9", int'({in_ready, hold_empty}), 3);
    start_frame(16'h0000, 2'b00, 2'b00, 2'b00, 1'b1, "R9");
    drain();
    check(txd == 1'b0, "R7", int'(txd), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule